// File: doc/BRIEF.md
# AGC Gain Step Rate Controller

This block steers the gain codes of two cascaded automatic gain control stages. Comparators on each stage output supply three level flags: first stage over its ceiling, second stage over its ceiling, and second stage under its floor. The controller turns these flags into a priority state. It then moves one gain code by one step each time a response timer expires. The timer period depends on the state, on a 2-bit response-time setting and on the selected first-stage step size.

Each state has its own direction. An overloaded first stage has its gain cut at the fastest rate. An overloaded second stage has its gain cut at a slower rate. A weak second-stage output raises gain, the second stage first and then the first stage once the second is at full gain. Both codes saturate at their limits. The timer counts clock ticks, with `TICKS_PER_US` ticks for each microsecond.

Top module: `agc_step_ctrl`

## Requirements
- R1: After reset, `gain0` equals `G0_MAX`, `gain1` equals `G1_MAX` and `state` is 0 (idle).
- R2: One clock after the flags are presented, `state` shows the priority result: 1 (A) if `agc0_over`, else 2 (B) if `agc1_over`, else 3 (C) if `agc1_under`, else 0 (idle).
- R3: In state A the per-step interval is floor(T × `TICKS_PER_US` / N) clocks, with N = `G0_MAX` / step size. T in µs is 560, 920, 1640 or 3080 for `resp_time` 0 to 3 with 1-code steps, and 380, 560, 930 or 1660 with 2-code steps.
- R4: In states B and C the interval is floor(T × `TICKS_PER_US` / `G1_MAX`) clocks. T is 8500, 8790, 9370 or 10520 µs for `resp_time` 0 to 3 with `agc0_big_step`=0, and 4350, 4500, 4790 or 5380 µs with `agc0_big_step`=1.
- R5: In state A each timer expiry lowers `gain0` by one step and leaves `gain1` unchanged. The step is 1 code when `agc0_big_step`=0 and 2 codes when it is 1.
- R6: In state B each expiry lowers `gain1` by 1 code and leaves `gain0` unchanged.
- R7: In state C each expiry raises `gain1` by 1 code while it is below `G1_MAX`. Once `gain1` is at `G1_MAX`, each expiry raises `gain0` by one step instead.
- R8: Gain codes saturate: they never go below 0 or above their maximum.
- R9: In idle no gain changes, and the step timer is cleared. A state entered afterwards waits its full interval before its first step.
- R10: A change of state restarts the timer. If the change falls in the cycle in which the old state's timer would have expired, no step is taken.
- R11: The gains change only at a timer expiry, so in a steady state there is at most one step per interval. Entering a state at a clock edge puts the first step exactly one interval of edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| resp_time | input | 2 | Response-time setting 0 to 3 (fast to slow) |
| agc0_big_step | input | 1 | 0: first-stage step 1 code; 1: 2 codes |
| agc0_over | input | 1 | First stage output above upper limit |
| agc1_over | input | 1 | Second stage output above upper limit |
| agc1_under | input | 1 | Second stage output below lower limit |
| gain0 | output | $clog2(G0_MAX+1) | First stage gain code |
| gain1 | output | $clog2(G1_MAX+1) | Second stage gain code |
| state | output | 2 | 0 idle, 1 A, 2 B, 3 C |

## Verification
A timer expiry and a state change can land on the same clock edge. In that case the restart has to win, and no step may be taken under either state. The bench enters state A and counts exactly one interval of negative edges. It then swaps the flags to state B just before the edge on which A would have stepped. It judges the result by checking that `gain0` has not moved, that `state` reads B, and that the first `gain1` step arrives only after a full state-B interval from the swap.

// File: rtl/agc_step_pkg.sv
`timescale 1ns/1ps
package agc_step_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_A    = 2'd1,
    ST_B    = 2'd2,
    ST_C    = 2'd3
  } agc_state_e;

  // Full-range swing time in microseconds.
  function automatic int unsigned swing_us(input logic [1:0] rt, input logic big,
                                           input logic fast);
    int unsigned t;
    case ({fast, big, rt})
      4'b1000: t = 560;   4'b1001: t = 920;   4'b1010: t = 1640;  4'b1011: t = 3080;
      4'b1100: t = 380;   4'b1101: t = 560;   4'b1110: t = 930;   4'b1111: t = 1660;
      4'b0000: t = 8500;  4'b0001: t = 8790;  4'b0010: t = 9370;  4'b0011: t = 10520;
      4'b0100: t = 4350;  4'b0101: t = 4500;  4'b0110: t = 4790;  4'b0111: t = 5380;
      default: t = 10520;
    endcase
    return t;
  endfunction

  // Clock ticks between two steps, never less than one.
  function automatic int unsigned step_ticks(input int unsigned us, input int unsigned tpu,
                                             input int unsigned steps);
    int unsigned s;
    int unsigned q;
    s = (steps == 0) ? 1 : steps;
    q = (us * tpu) / s;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic int sat_down(input int v, input int d);
    return (v < d) ? 0 : v - d;
  endfunction

  function automatic int sat_up(input int v, input int d, input int lim);
    return (v + d > lim) ? lim : v + d;
  endfunction

endpackage

// File: rtl/agc_state_sel.sv
`timescale 1ns/1ps
module agc_state_sel
  import agc_step_pkg::*;
(
  input  logic       over0,
  input  logic       over1,
  input  logic       under1,
  output agc_state_e st
);
  always_comb begin
    if (over0)       st = ST_A;
    else if (over1)  st = ST_B;
    else if (under1) st = ST_C;
    else             st = ST_IDLE;
  end
endmodule

// File: rtl/agc_step_timer.sv
`timescale 1ns/1ps
module agc_step_timer
  import agc_step_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 1,
  parameter int unsigned G0_MAX = 16,
  parameter int unsigned G1_MAX = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  agc_state_e st_now,
  input  logic [1:0] rt,
  input  logic       big,
  output agc_state_e st_q,
  output logic       step
);
  localparam int CNT_W = $clog2(10520 * TICKS_PER_US + 1) + 1;
  typedef logic [CNT_W-1:0] cnt_t;

  cnt_t        cnt;
  cnt_t        ivl;
  logic        restart;
  int unsigned steps;

  always_comb begin
    if (st_q == ST_A) steps = big ? G0_MAX / 2 : G0_MAX;
    else              steps = G1_MAX;
    ivl = cnt_t'(step_ticks(swing_us(rt, big, st_q == ST_A), TICKS_PER_US, steps));
  end

  assign restart = (st_now != st_q) || (st_q == ST_IDLE);
  assign step    = !restart && (cnt >= ivl - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      cnt  <= '0;
    end else begin
      st_q <= st_now;
      if (restart || step) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_now != st_q) |=> (cnt == '0)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !step); // R9
endmodule

// File: rtl/agc_gain_regs.sv
`timescale 1ns/1ps
module agc_gain_regs
  import agc_step_pkg::*;
#(
  parameter int unsigned G0_MAX = 16,
  parameter int unsigned G1_MAX = 16,
  localparam int G0_W = $clog2(G0_MAX + 1),
  localparam int G1_W = $clog2(G1_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  agc_state_e      st,
  input  logic            big,
  output logic [G0_W-1:0] gain0,
  output logic [G1_W-1:0] gain1
);
  int d0;
  assign d0 = big ? 2 : 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain0 <= G0_W'(G0_MAX);
      gain1 <= G1_W'(G1_MAX);
    end else if (step) begin
      case (st)
        ST_A: gain0 <= G0_W'(sat_down(int'(gain0), d0));
        ST_B: gain1 <= G1_W'(sat_down(int'(gain1), 1));
        ST_C: begin
          if (int'(gain1) < int'(G1_MAX)) gain1 <= G1_W'(sat_up(int'(gain1), 1, int'(G1_MAX)));
          else gain0 <= G0_W'(sat_up(int'(gain0), d0, int'(G0_MAX)));
        end
        default: ;
      endcase
    end
  end

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(gain0) && $stable(gain1))); // R11
  AST_A_KEEPS_GAIN1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == ST_A) |=> $stable(gain1)); // R5
  AST_B_KEEPS_GAIN0: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == ST_B) |=> $stable(gain0)); // R6
  AST_C_GAIN1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == ST_C && int'(gain1) < int'(G1_MAX)) |=> $stable(gain0)); // R7
  AST_GAIN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gain0) <= int'(G0_MAX)) && (int'(gain1) <= int'(G1_MAX))); // R8
endmodule

// File: rtl/agc_step_ctrl.sv
`timescale 1ns/1ps
module agc_step_ctrl
  import agc_step_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 1,
  parameter int unsigned G0_MAX = 16,
  parameter int unsigned G1_MAX = 16,
  localparam int G0_W = $clog2(G0_MAX + 1),
  localparam int G1_W = $clog2(G1_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      resp_time,
  input  logic            agc0_big_step,
  input  logic            agc0_over,
  input  logic            agc1_over,
  input  logic            agc1_under,
  output logic [G0_W-1:0] gain0,
  output logic [G1_W-1:0] gain1,
  output logic [1:0]      state
);
  agc_state_e st_now;
  agc_state_e st_q;
  logic       step_evt;

  agc_state_sel u_sel (
    .over0 (agc0_over),
    .over1 (agc1_over),
    .under1(agc1_under),
    .st    (st_now)
  );

  agc_step_timer #(
    .TICKS_PER_US(TICKS_PER_US),
    .G0_MAX      (G0_MAX),
    .G1_MAX      (G1_MAX)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .st_now(st_now),
    .rt    (resp_time),
    .big   (agc0_big_step),
    .st_q  (st_q),
    .step  (step_evt)
  );

  agc_gain_regs #(
    .G0_MAX(G0_MAX),
    .G1_MAX(G1_MAX)
  ) u_gain (
    .clk  (clk),
    .rst_n(rst_n),
    .step (step_evt),
    .st   (st_q),
    .big  (agc0_big_step),
    .gain0(gain0),
    .gain1(gain1)
  );

  assign state = st_q;

  AST_A_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    agc0_over |=> (state == 2'd1)); // R2
  AST_B_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!agc0_over && agc1_over) |=> (state == 2'd2)); // R2
endmodule

// File: tb/test_agc_step_ctrl.sv
`timescale 1ns/1ps
module test_agc_step_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TPU = 1;
  localparam int GM0 = 16;
  localparam int GM1 = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] resp_time = 2'd0;
  logic       agc0_big_step = 1'b0;
  logic       agc0_over = 1'b0;
  logic       agc1_over = 1'b0;
  logic       agc1_under = 1'b0;
  logic [4:0] gain0;
  logic [4:0] gain1;
  logic [1:0] state;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  agc_step_ctrl #(.TICKS_PER_US(TPU), .G0_MAX(GM0), .G1_MAX(GM1)) i_agc_step_ctrl (
    .clk(clk), .rst_n(rst_n), .resp_time(resp_time), .agc0_big_step(agc0_big_step),
    .agc0_over(agc0_over), .agc1_over(agc1_over), .agc1_under(agc1_under),
    .gain0(gain0), .gain1(gain1), .state(state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected interval, from times held in hundredths of a millisecond.
  function automatic int exp_ivl(input bit in_a, input int rt, input bit big);
    int a1[4] = '{56, 92, 164, 308};
    int a2[4] = '{38, 56, 93, 166};
    int s1[4] = '{850, 879, 937, 1052};
    int s2[4] = '{435, 450, 479, 538};
    int ms100;
    int n;
    if (in_a) begin
      ms100 = big ? a2[rt] : a1[rt];
      n = big ? GM0 / 2 : GM0;
    end else begin
      ms100 = big ? s2[rt] : s1[rt];
      n = GM1;
    end
    return (ms100 * 10 * TPU) / n;
  endfunction

  task automatic set_flags(input bit o0, input bit o1, input bit u1);
    agc0_over = o0; agc1_over = o1; agc1_under = u1;
  endtask

  task automatic go_idle();
    @(negedge clk); set_flags(0, 0, 0);
    @(negedge clk); @(negedge clk);
  endtask

  // Counts negedges until either gain moves.
  task automatic measure(output int n, input int limit);
    logic [4:0] g0 = gain0;
    logic [4:0] g1 = gain1;
    n = 0;
    while (n < limit) begin
      @(negedge clk); n++;
      if (gain0 != g0 || gain1 != g1) break;
    end
  endtask

  task automatic t_reset();
    chk("R1 gain0", gain0, GM0);
    chk("R1 gain1", gain1, GM1);
    chk("R1 state", state, 0);
  endtask

  task automatic t_priority();
    for (int i = 0; i < 8; i++) begin
      int e;
      @(negedge clk); set_flags(i[2], i[1], i[0]);
      e = i[2] ? 1 : i[1] ? 2 : i[0] ? 3 : 0;
      @(negedge clk);
      chk("R2 state", state, e);
    end
  endtask

  task automatic t_state_a();
    int n;
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 4; r++) begin
        int p0;
        int p1;
        go_idle();
        resp_time = 2'(r); agc0_big_step = b[0];
        p0 = gain0; p1 = gain1;
        set_flags(1, 0, 0);
        measure(n, 1000);
        chk("R3 interval A", n, exp_ivl(1, r, b[0]) + 1);
        chk("R5 gain0 step", gain0, p0 - (b ? 2 : 1));
        chk("R5 gain1 held", gain1, p1);
      end
    end
    repeat (4 * (exp_ivl(1, 3, 1) + 1)) @(negedge clk);
    chk("R8 gain0 floor", gain0, 0);
  endtask

  task automatic t_state_b();
    int n;
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 4; r++) begin
        int p1;
        go_idle();
        resp_time = 2'(r); agc0_big_step = b[0];
        p1 = gain1;
        set_flags(0, 1, 0);
        measure(n, 2000);
        chk("R4 interval B", n, exp_ivl(0, r, b[0]) + 1);
        chk("R6 gain1 step", gain1, p1 - 1);
        chk("R6 gain0 held", gain0, 0);
      end
    end
    resp_time = 2'd0;
    repeat (9 * (exp_ivl(0, 0, 1) + 1)) @(negedge clk);
    chk("R8 gain1 floor", gain1, 0);
  endtask

  task automatic t_state_c();
    int n;
    for (int k = 0; k < 24; k++) begin
      int p0;
      int p1;
      bit b = (k >= 16);
      int r = b ? 1 : 0;
      go_idle();
      resp_time = 2'(r); agc0_big_step = b;
      p0 = gain0; p1 = gain1;
      set_flags(0, 0, 1);
      measure(n, 2000);
      chk("R4 interval C", n, exp_ivl(0, r, b) + 1);
      if (p1 < GM1) begin
        chk("R7 gain1 raise", gain1, p1 + 1);
        chk("R7 gain0 wait", gain0, p0);
      end else begin
        chk("R7 gain0 raise", gain0, p0 + (b ? 2 : 1));
        chk("R7 gain1 full", gain1, GM1);
      end
    end
    repeat (3 * (exp_ivl(0, 1, 1) + 1)) @(negedge clk);
    chk("R8 gain0 ceiling", gain0, GM0);
    chk("R8 gain1 ceiling", gain1, GM1);
  endtask

  task automatic t_idle();
    int n;
    go_idle();
    repeat (1000) @(negedge clk);
    chk("R9 idle gain0", gain0, GM0);
    chk("R9 idle gain1", gain1, GM1);
    chk("R9 idle state", state, 0);
    resp_time = 2'd0; agc0_big_step = 1'b0;
    set_flags(1, 0, 0);
    repeat (exp_ivl(1, 0, 0) - 5) @(negedge clk);
    set_flags(0, 0, 0);
    @(negedge clk);
    set_flags(1, 0, 0);
    measure(n, 1000);
    chk("R9 timer cleared", n, exp_ivl(1, 0, 0) + 1);
    chk("R11 single step", gain0, GM0 - 1);
  endtask

  task automatic t_collision();
    int n;
    go_idle();
    resp_time = 2'd0; agc0_big_step = 1'b0;
    set_flags(1, 0, 0);
    repeat (exp_ivl(1, 0, 0)) @(negedge clk);
    chk("R11 no early step", gain0, GM0 - 1);
    set_flags(0, 1, 0);
    @(negedge clk);
    chk("R10 step suppressed", gain0, GM0 - 1);
    chk("R10 state B", state, 2);
    measure(n, 2000);
    chk("R10 restart interval", n, exp_ivl(0, 0, 0));
    chk("R10 gain1 step", gain1, GM1 - 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_state_a();
    t_state_b();
    t_state_c();
    t_idle();
    t_collision();
    finish_run();
  end
endmodule